// File: doc/BRIEF.md
# DMA Burst Segmentation Engine

This block turns one memory-to-memory copy into a series of legal bus bursts. It is given a source start address, a destination start address and a length counted in 64-bit double words. It then issues read-burst and write-burst requests, one at a time, on a single request channel with a valid/ready handshake. Each request carries a byte address, a double-word count and a read/write flag. Words returned by the reads enter an 8-entry, 64-bit staging FIFO. The write side drains that FIFO in source order, so the read and the write streams can have different alignments.

The burst length is not fixed. It is worked out for every request from the address alignment on that side, from a rule that no burst may cross a 256-byte line, from a size-mode input and from the words still to move. Bursts are used only when the FIFO is enabled and the size code selects 4 or 8 words. Otherwise the engine moves one word per request.

The block starts on a one-cycle `start` pulse and reports the end of the copy with a one-cycle `done` pulse. A request with a misaligned address or a zero length is rejected with a one-cycle `err` pulse, and no transfer starts.

Top module: `dma_burst_seg`

## Requirements
- R1: The burst size B is 4 when `bsize_code`=2 and 8 when `bsize_code`=3, in both cases only with `fifo_en`=1. Every other combination (codes 0 and 1, or `fifo_en`=0) gives B=1, so every request has `req_cnt`=1.
- R2: With `size_mode`=0, a request on either side at double-word index a with r words left has count min(B - (a mod B), r). Example: a source at byte offset 0xA8 with B=8 has a first read count of 3.
- R3: With `size_mode`=1, a request has count min(B, 32 - (a mod 32), r), where a is the double-word index (`req_addr`[31:3]) on that side. If the FIFO has no room for that count, R5 applies.
- R4: No request crosses a 32-double-word (256-byte) address boundary: `req_addr`[7:3] + `req_cnt` <= 32.
- R5: A read request is issued only if the words held, plus the read words still due, plus its count, fit in the 8 FIFO entries. When no write can be issued, no read words are due and the full count does not fit, the read is trimmed to the free space instead.
- R6: A write request is issued only if the FIFO holds at least `req_cnt` words that are not yet claimed by an earlier write request. `drain_valid` is high exactly while write words are owed.
- R7: The k-th word presented on `drain_data` with `drain_ready` high is the k-th word accepted on `fill_data`, so the data arrives in source order.
- R8: `req_addr`, `req_cnt` and `req_wr` hold steady while `req_valid` is high and `req_ready` is low. On each side, successive addresses follow on from each other, starting at that side's start address.
- R9: `done` is a one-cycle pulse. It is raised once every word has been requested on both sides and the FIFO has drained. At that point `busy` falls and no request is pending.
- R10: A `start` with `src_addr`[2:0]!=0, `dst_addr`[2:0]!=0 or `len_dw`=0 raises `err` for exactly one cycle. `busy` stays low and no request is made.
- R11: A `start` pulse while `busy` is high is ignored. The running copy keeps its original addresses and length.
- R12: After reset, `busy`, `done`, `err`, `req_valid` and `drain_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a copy with the arguments below |
| src_addr | input | 32 | Source start byte address |
| dst_addr | input | 32 | Destination start byte address |
| len_dw | input | 16 | Length in double words |
| bsize_code | input | 2 | Burst size code: 0=1, 1=2, 2=4, 3=8 words |
| fifo_en | input | 1 | Allow bursts through the staging FIFO |
| size_mode | input | 1 | 1: full-size bursts cut only at 256-byte lines; 0: align to the burst size |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle end-of-copy pulse |
| err | output | 1 | One-cycle rejected-start pulse |
| req_valid | output | 1 | Burst request valid |
| req_ready | input | 1 | Burst request accepted |
| req_wr | output | 1 | 1 = write burst, 0 = read burst |
| req_addr | output | 32 | Burst start byte address |
| req_cnt | output | 4 | Burst length in double words |
| fill_valid | input | 1 | Read data word valid |
| fill_data | input | 64 | Read data word |
| drain_valid | output | 1 | Write data word valid |
| drain_ready | input | 1 | Write data word taken |
| drain_data | output | 64 | Write data word |

## Verification
A request becomes visible one cycle after the engine decides to make it. A read request's words count as due from the edge on which that request is accepted. `err` is due on the edge that samples the bad `start`, and `done` one edge after the drained state is reached. The bench drives all inputs and samples all outputs on the falling edge. A request or data word seen there with its ready high is taken as a handshake at the following rising edge, and the behavioural model is updated at that same point. On every cycle `drain_valid` and the data word are compared with the model's count of owed write words and its word queue. Each accepted request is checked against the sizing formula and the FIFO space as it stands in that cycle. The err and done pulses are checked on the exact falling edge where they are due and on the one after it.

// File: rtl/dma_seg_pkg.sv
package dma_seg_pkg;
  // size codes on the bsize_code input
  typedef enum logic [1:0] {
    BSZ_ONE   = 2'd0,
    BSZ_TWO   = 2'd1,
    BSZ_FOUR  = 2'd2,
    BSZ_EIGHT = 2'd3
  } bsize_e;

  localparam int SIDE_RD = 0;
  localparam int SIDE_WR = 1;

  // bursts only for four or eight words with the FIFO enabled
  function automatic int unsigned eff_burst(input logic [1:0] code, input logic en);
    if (en && (code == BSZ_FOUR || code == BSZ_EIGHT))
      return 32'd1 << code;
    return 32'd1;
  endfunction
endpackage

// File: rtl/dma_seg_rst_sync.sv
module dma_seg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_n_s <= meta_q;
    end
  end
endmodule

// File: rtl/dma_seg_burst_calc.sv
// Burst length for one side: alignment or line limit, then remaining words.
module dma_seg_burst_calc #(
  parameter int DW_W     = 29,
  parameter int LEN_W    = 16,
  parameter int CNT_W    = 4,
  parameter int BOUND_DW = 32
) (
  input  logic [DW_W-1:0]  addr_dw,
  input  logic [LEN_W-1:0] left,
  input  logic [CNT_W-1:0] bsz,
  input  logic             mode,
  output logic [CNT_W-1:0] cnt
);
  localparam int BW  = $clog2(BOUND_DW) + 1;
  localparam int OFW = BW - 1;

  logic [CNT_W-1:0] off_b, lim_align, lim_line, lim;
  logic [BW-1:0]    to_line;

  always_comb begin
    off_b     = addr_dw[CNT_W-1:0] & (bsz - CNT_W'(1));
    lim_align = bsz - off_b;
    to_line   = BW'(BOUND_DW) - {1'b0, addr_dw[OFW-1:0]};
    lim_line  = (to_line < BW'(bsz)) ? to_line[CNT_W-1:0] : bsz;
    lim       = mode ? lim_line : lim_align;
    cnt       = (left < LEN_W'(lim)) ? left[CNT_W-1:0] : lim;
  end
endmodule

// File: rtl/dma_seg_fifo.sv
module dma_seg_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [WIDTH-1:0]           push_data,
  input  logic                       pop,
  output logic [WIDTH-1:0]           pop_data,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_n, rptr_q, rptr_n;
  logic [CW-1:0]    cnt_q, cnt_n;

  always_comb begin
    wptr_n = push ? wptr_q + PTR_W'(1) : wptr_q;
    rptr_n = pop  ? rptr_q + PTR_W'(1) : rptr_q;
    cnt_n  = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= push_data;
  end

  assign pop_data = mem[rptr_q];
  assign count    = cnt_q;
endmodule

// File: rtl/dma_burst_seg.sv
module dma_burst_seg #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int DATA_W     = 64,
  parameter int FIFO_DEPTH = 8,
  parameter int BOUND_DW   = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic [ADDR_W-1:0]                  src_addr,
  input  logic [ADDR_W-1:0]                  dst_addr,
  input  logic [LEN_W-1:0]                   len_dw,
  input  logic [1:0]                         bsize_code,
  input  logic                               fifo_en,
  input  logic                               size_mode,
  output logic                               busy,
  output logic                               done,
  output logic                               err,
  output logic                               req_valid,
  input  logic                               req_ready,
  output logic                               req_wr,
  output logic [ADDR_W-1:0]                  req_addr,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]    req_cnt,
  input  logic                               fill_valid,
  input  logic [DATA_W-1:0]                  fill_data,
  output logic                               drain_valid,
  input  logic                               drain_ready,
  output logic [DATA_W-1:0]                  drain_data
);
  import dma_seg_pkg::*;

  localparam int DW_W  = ADDR_W - 3;
  localparam int CNT_W = $clog2(FIFO_DEPTH+1);
  localparam int SUM_W = CNT_W + 2;

  logic rst_n_s;

  // control state
  logic             busy_q, busy_n, done_q, done_n, err_q, err_n;
  logic             mode_q, mode_n;
  logic [CNT_W-1:0] bsz_q, bsz_n;
  logic [DW_W-1:0]  rd_dw_q, rd_dw_n, wr_dw_q, wr_dw_n;
  logic [LEN_W-1:0] rd_left_q, rd_left_n, wr_left_q, wr_left_n;
  logic [CNT_W-1:0] rd_pend_q, rd_pend_n, wr_pend_q, wr_pend_n;
  // request register
  logic              req_valid_q, req_valid_n, req_wr_q, req_wr_n;
  logic [ADDR_W-1:0] req_addr_q, req_addr_n;
  logic [CNT_W-1:0]  req_cnt_q, req_cnt_n;

  logic [CNT_W-1:0] occ;
  logic [DW_W-1:0]  side_dw   [2];
  logic [LEN_W-1:0] side_left [2];
  logic [CNT_W-1:0] side_cnt  [2];

  logic             hs, fill_acc, drain_fire, bad_req;
  logic             can_wr, rd_full_fit, rd_trim, can_rd, all_clear;
  logic [SUM_W-1:0] room;
  logic [CNT_W-1:0] rd_cnt_eff;

  dma_seg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  assign side_dw[SIDE_RD]   = rd_dw_q;
  assign side_dw[SIDE_WR]   = wr_dw_q;
  assign side_left[SIDE_RD] = rd_left_q;
  assign side_left[SIDE_WR] = wr_left_q;

  for (genvar s = 0; s < 2; s++) begin : g_side
    dma_seg_burst_calc #(
      .DW_W(DW_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .BOUND_DW(BOUND_DW)
    ) u_calc (
      .addr_dw(side_dw[s]),
      .left   (side_left[s]),
      .bsz    (bsz_q),
      .mode   (mode_q),
      .cnt    (side_cnt[s])
    );
  end

  assign hs         = req_valid_q && req_ready;
  assign fill_acc   = fill_valid && (rd_pend_q != '0);
  assign drain_fire = drain_ready && (wr_pend_q != '0);

  dma_seg_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .push     (fill_acc),
    .push_data(fill_data),
    .pop      (drain_fire),
    .pop_data (drain_data),
    .count    (occ)
  );

  // issue conditions
  always_comb begin
    bad_req     = (src_addr[2:0] != 3'd0) || (dst_addr[2:0] != 3'd0) || (len_dw == '0);
    room        = SUM_W'(FIFO_DEPTH) - SUM_W'(occ) - SUM_W'(rd_pend_q);
    can_wr      = (wr_left_q != '0) && ((occ - wr_pend_q) >= side_cnt[SIDE_WR]);
    rd_full_fit = (rd_left_q != '0) && (SUM_W'(side_cnt[SIDE_RD]) <= room);
    rd_trim     = (rd_left_q != '0) && !can_wr && (rd_pend_q == '0) && (room != '0);
    can_rd      = rd_full_fit || rd_trim;
    rd_cnt_eff  = rd_full_fit ? side_cnt[SIDE_RD] : room[CNT_W-1:0];
    all_clear   = (rd_left_q == '0) && (wr_left_q == '0) && (rd_pend_q == '0) &&
                  (wr_pend_q == '0) && (occ == '0);
  end

  // next state
  always_comb begin
    busy_n      = busy_q;
    done_n      = 1'b0;
    err_n       = 1'b0;
    mode_n      = mode_q;
    bsz_n       = bsz_q;
    rd_dw_n     = rd_dw_q;
    wr_dw_n     = wr_dw_q;
    rd_left_n   = rd_left_q;
    wr_left_n   = wr_left_q;
    req_valid_n = req_valid_q;
    req_wr_n    = req_wr_q;
    req_addr_n  = req_addr_q;
    req_cnt_n   = req_cnt_q;
    rd_pend_n   = rd_pend_q + ((hs && !req_wr_q) ? req_cnt_q : '0) - CNT_W'(fill_acc);
    wr_pend_n   = wr_pend_q + ((hs &&  req_wr_q) ? req_cnt_q : '0) - CNT_W'(drain_fire);

    if (!busy_q) begin
      if (start) begin
        if (bad_req) begin
          err_n = 1'b1;
        end else begin
          busy_n    = 1'b1;
          mode_n    = size_mode;
          bsz_n     = CNT_W'(eff_burst(bsize_code, fifo_en));
          rd_dw_n   = src_addr[ADDR_W-1:3];
          wr_dw_n   = dst_addr[ADDR_W-1:3];
          rd_left_n = len_dw;
          wr_left_n = len_dw;
        end
      end
    end else if (hs) begin
      req_valid_n = 1'b0;
      if (req_wr_q) begin
        wr_dw_n   = wr_dw_q + DW_W'(req_cnt_q);
        wr_left_n = wr_left_q - LEN_W'(req_cnt_q);
      end else begin
        rd_dw_n   = rd_dw_q + DW_W'(req_cnt_q);
        rd_left_n = rd_left_q - LEN_W'(req_cnt_q);
      end
    end else if (!req_valid_q) begin
      if (can_wr) begin
        req_valid_n = 1'b1;
        req_wr_n    = 1'b1;
        req_addr_n  = {wr_dw_q, 3'b000};
        req_cnt_n   = side_cnt[SIDE_WR];
      end else if (can_rd) begin
        req_valid_n = 1'b1;
        req_wr_n    = 1'b0;
        req_addr_n  = {rd_dw_q, 3'b000};
        req_cnt_n   = rd_cnt_eff;
      end else if (all_clear) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      mode_q      <= 1'b0;
      bsz_q       <= '0;
      rd_dw_q     <= '0;
      wr_dw_q     <= '0;
      rd_left_q   <= '0;
      wr_left_q   <= '0;
      rd_pend_q   <= '0;
      wr_pend_q   <= '0;
      req_valid_q <= 1'b0;
      req_wr_q    <= 1'b0;
      req_addr_q  <= '0;
      req_cnt_q   <= '0;
    end else begin
      busy_q      <= busy_n;
      done_q      <= done_n;
      err_q       <= err_n;
      mode_q      <= mode_n;
      bsz_q       <= bsz_n;
      rd_dw_q     <= rd_dw_n;
      wr_dw_q     <= wr_dw_n;
      rd_left_q   <= rd_left_n;
      wr_left_q   <= wr_left_n;
      rd_pend_q   <= rd_pend_n;
      wr_pend_q   <= wr_pend_n;
      req_valid_q <= req_valid_n;
      req_wr_q    <= req_wr_n;
      req_addr_q  <= req_addr_n;
      req_cnt_q   <= req_cnt_n;
    end
  end

  assign busy        = busy_q;
  assign done        = done_q;
  assign err         = err_q;
  assign req_valid   = req_valid_q;
  assign req_wr      = req_wr_q;
  assign req_addr    = req_addr_q;
  assign req_cnt     = req_cnt_q;
  assign drain_valid = (wr_pend_q != '0);
endmodule

// File: rtl/dma_seg_chk.sv
module dma_seg_chk #(
  parameter int ADDR_W     = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int BOUND_DW   = 32
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            busy,
  input logic                            done,
  input logic                            err,
  input logic                            req_valid,
  input logic                            req_ready,
  input logic                            req_wr,
  input logic [ADDR_W-1:0]               req_addr,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] req_cnt,
  input logic                            drain_valid
);
  localparam int LHI = $clog2(BOUND_DW) + 2;

  // R4: no request runs over a 256-byte line
  a_r4_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (int'(req_addr[LHI:3]) + int'(req_cnt)) <= BOUND_DW);

  // R5, R6: a burst never exceeds the staging FIFO and is never empty
  a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_cnt != '0) && (int'(req_cnt) <= FIFO_DEPTH));

  // R8: request fields are held until accepted
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid && $stable(req_addr) &&
                                  $stable(req_cnt) && $stable(req_wr));

  // R9: done is a single-cycle pulse with the engine idle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !req_valid && !drain_valid);

  // R10: a rejected start leaves the engine idle
  a_r10_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !busy && !req_valid);

  a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);
endmodule

bind dma_burst_seg dma_seg_chk #(
  .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .BOUND_DW(BOUND_DW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_wr     (req_wr),
  .req_addr   (req_addr),
  .req_cnt    (req_cnt),
  .drain_valid(drain_valid)
);

// File: tb/dma_burst_seg_tb_top.sv
module dma_burst_seg_tb_top;
  logic        clk, rst_n, start;
  logic [31:0] src_addr, dst_addr;
  logic [15:0] len_dw;
  logic [1:0]  bsize_code;
  logic        fifo_en, size_mode;
  logic        busy, done, err;
  logic        req_valid, req_ready, req_wr;
  logic [31:0] req_addr;
  logic [3:0]  req_cnt;
  logic        fill_valid, drain_valid, drain_ready;
  logic [63:0] fill_data, drain_data;

  int checks = 0, errors = 0, cyc = 0;
  bit wd = 0;
  localparam int WD_LIMIT = 150000;

  // behavioural model state
  int m_src0, m_rd_dw, m_wr_dw, m_rd_left, m_wr_left;
  int m_rd_out, m_wr_out, m_occ, m_fill_idx, m_wr_idx, m_b, m_first_rd;
  bit m_mode;

  dma_burst_seg dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr), .dst_addr(dst_addr),
    .len_dw(len_dw), .bsize_code(bsize_code), .fifo_en(fifo_en), .size_mode(size_mode),
    .busy(busy), .done(done), .err(err), .req_valid(req_valid), .req_ready(req_ready),
    .req_wr(req_wr), .req_addr(req_addr), .req_cnt(req_cnt), .fill_valid(fill_valid),
    .fill_data(fill_data), .drain_valid(drain_valid), .drain_ready(drain_ready),
    .drain_data(drain_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int dw);
    return {~32'(dw), 32'(dw)};
  endfunction

  function automatic int eff_b(input logic [1:0] code, input bit en);
    return (en && code >= 2'd2) ? (1 << code) : 1;
  endfunction

  function automatic int exp_cnt(input int dw, input int left, input int b, input bit mode);
    int lim;
    if (mode) begin
      lim = 32 - (dw % 32);
      if (b < lim) lim = b;
    end else begin
      lim = b - (dw % b);
    end
    if (left < lim) lim = left;
    return lim;
  endfunction

  task automatic check_req();
    int c, e;
    c = int'(req_cnt);
    chk(((int'(req_addr[7:3])) + c) <= 32, "R4 line crossing", 64'(req_addr), 64'(c));
    if (req_wr) begin
      e = exp_cnt(m_wr_dw, m_wr_left, m_b, m_mode);
      chk(c == e, m_b == 1 ? "R1 single write count" : (m_mode ? "R3 write count" : "R2 write count"), 64'(c), 64'(e));
      chk(req_addr == 32'(m_wr_dw * 8), "R8 write address", 64'(req_addr), 64'(m_wr_dw * 8));
      chk((m_occ - m_wr_out) >= c, "R6 write data held", 64'(m_occ - m_wr_out), 64'(c));
      m_wr_dw += c; m_wr_left -= c; m_wr_out += c;
    end else begin
      e = exp_cnt(m_rd_dw, m_rd_left, m_b, m_mode);
      chk(c >= 1 && c <= e, m_b == 1 ? "R1 single read count" : (m_mode ? "R3 read count" : "R2 read count"), 64'(c), 64'(e));
      chk(req_addr == 32'(m_rd_dw * 8), "R8 read address", 64'(req_addr), 64'(m_rd_dw * 8));
      chk((m_occ + m_rd_out + c) <= 8, "R5 fifo room", 64'(m_occ + m_rd_out + c), 64'd8);
      if (m_first_rd < 0) m_first_rd = c;
      m_rd_dw += c; m_rd_left -= c; m_rd_out += c;
    end
  endtask

  // one clock: drive and compare on the falling edge
  task automatic step();
    @(negedge clk);
    cyc++;
    if (cyc > WD_LIMIT) wd = 1;
    drain_ready = ($urandom % 4) != 0;
    chk(drain_valid == (m_wr_out > 0), "R6 drain_valid", 64'(drain_valid), 64'(m_wr_out > 0));
    if (drain_valid && drain_ready) begin
      chk(drain_data == pat(m_src0 + m_wr_idx), "R7 data order", drain_data, pat(m_src0 + m_wr_idx));
      m_wr_idx++; m_wr_out--; m_occ--;
    end
    fill_valid = 1'b0;
    if (m_rd_out > 0 && ($urandom % 3) != 0) begin
      fill_valid = 1'b1;
      fill_data  = pat(m_src0 + m_fill_idx);
      m_fill_idx++; m_rd_out--; m_occ++;
      chk(m_occ <= 8, "R5 fifo depth", 64'(m_occ), 64'd8);
    end
    req_ready = ($urandom % 3) != 0;
    if (req_valid && req_ready) check_req();
  endtask

  task automatic run(input logic [31:0] s, input logic [31:0] d, input int len,
                     input logic [1:0] code, input bit en, input bit mode, input int inject_at);
    bit got;
    int n;
    m_src0 = int'(s >> 3); m_rd_dw = m_src0; m_wr_dw = int'(d >> 3);
    m_rd_left = len; m_wr_left = len; m_rd_out = 0; m_wr_out = 0; m_occ = 0;
    m_fill_idx = 0; m_wr_idx = 0; m_b = eff_b(code, en); m_mode = mode; m_first_rd = -1;
    src_addr = s; dst_addr = d; len_dw = 16'(len); bsize_code = code;
    fifo_en = en; size_mode = mode; start = 1'b1;
    step();
    start = 1'b0;
    got = 0; n = 0;
    while (!got && n < 4000 && !wd) begin
      if (n == inject_at) begin
        start = 1'b1; src_addr = s + 32'd64; dst_addr = d + 32'd64; len_dw = 16'd3;
      end
      step();
      start = 1'b0;
      chk(!err, "R11 no err while busy", 64'(err), 64'd0);
      n++;
      if (done) got = 1;
    end
    chk(got, "R9 done raised", 64'(got), 64'd1);
    chk(m_wr_idx == len, "R9 R11 words written", 64'(m_wr_idx), 64'(len));
    chk(m_rd_left == 0 && m_wr_left == 0, "R9 all requested", 64'(m_rd_left + m_wr_left), 64'd0);
    chk(!busy, "R9 busy low at done", 64'(busy), 64'd0);
    step();
    chk(!done, "R9 done single pulse", 64'(done), 64'd0);
  endtask

  task automatic err_case(input logic [31:0] s, input logic [31:0] d, input int len, input string tag);
    src_addr = s; dst_addr = d; len_dw = 16'(len); bsize_code = 2'd3;
    fifo_en = 1'b1; size_mode = 1'b0; start = 1'b1;
    step();
    start = 1'b0;
    chk(err, {"R10 err raised ", tag}, 64'(err), 64'd1);
    chk(!busy, {"R10 no start ", tag}, 64'(busy), 64'd0);
    for (int i = 0; i < 4; i++) begin
      step();
      chk(!err && !req_valid && !busy, {"R10 stays idle ", tag}, 64'({err, req_valid, busy}), 64'd0);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; src_addr = '0; dst_addr = '0; len_dw = '0;
    bsize_code = '0; fifo_en = 1'b0; size_mode = 1'b0; req_ready = 1'b0;
    fill_valid = 1'b0; fill_data = '0; drain_ready = 1'b0;
    m_src0 = 0; m_rd_dw = 0; m_wr_dw = 0; m_rd_left = 0; m_wr_left = 0;
    m_rd_out = 0; m_wr_out = 0; m_occ = 0; m_fill_idx = 0; m_wr_idx = 0;
    m_b = 1; m_mode = 0; m_first_rd = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step();
    // R12 reset state
    chk(!busy && !done && !err && !req_valid && !drain_valid, "R12 reset outputs",
        64'({busy, done, err, req_valid, drain_valid}), 64'd0);

    // R10 rejected starts
    err_case(32'h1004, 32'h2000, 8, "src");
    err_case(32'h1000, 32'h2002, 8, "dst");
    err_case(32'h1000, 32'h2000, 0, "len");

    // R2 equal offsets, first burst trimmed to alignment
    run(32'h0000_10A8, 32'h0000_2028, 19, 2'd3, 1'b1, 1'b0, -1);
    chk(m_first_rd == 3, "R2 first read burst of 3", 64'(m_first_rd), 64'd3);
    // R2 differing offsets
    run(32'h0000_10A8, 32'h0000_2030, 20, 2'd3, 1'b1, 1'b0, -1);
    // R3 full-size bursts, cut at lines
    run(32'h0000_10A8, 32'h0000_2038, 20, 2'd3, 1'b1, 1'b1, -1);
    // R3 with four-word bursts straddling a line
    run(32'h0000_30F0, 32'h0000_40E8, 23, 2'd2, 1'b1, 1'b1, -1);
    // R2 with four-word bursts
    run(32'h0000_5018, 32'h0000_6008, 17, 2'd2, 1'b1, 1'b0, -1);
    // R1 singles: FIFO disabled, and two-word code
    run(32'h0000_7000, 32'h0000_8010, 9, 2'd3, 1'b0, 1'b1, -1);
    run(32'h0000_7040, 32'h0000_8080, 6, 2'd1, 1'b1, 1'b0, -1);
    // R11 start while busy ignored
    run(32'h0000_9008, 32'h0000_A0F8, 30, 2'd3, 1'b1, 1'b1, 6);
    // short copy, length below burst size
    run(32'h0000_B000, 32'h0000_C000, 2, 2'd3, 1'b1, 1'b0, -1);

    if (wd) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WD_LIMIT);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule